// File: doc/BRIEF.md
# Debug Pin Read Handshake Controller

This block is the target-side engine behind a single open-drain debug pin. It accepts a read command from a host over that pin, fetches one word over a simple memory bus, and then tells the host that the word is ready. The command is a 24-bit serial frame: an 8-bit opcode followed by a 16-bit address, both most significant bit first. Bit-cell timing is handled outside this block. Here, every host bit shows up as a strobe (`bit_stb_i`) together with the sampled pin level (`pin_i`), and both are taken only on a debug clock tick (`dbg_tick_i`). All of the block's internal timing counts these ticks, not core clocks.

When the opcode matches `RD_OP`, the block requests the bus and waits for the grant and the read data. It then starts an acknowledge, which is the only point at which the target itself produces a falling edge. The acknowledge holds the pin low for a fixed number of ticks, drives it high for a single speedup tick, and then releases it. The acknowledge never begins before a minimum decode delay has passed. If the data is late, the pin simply stays released until the data arrives.

After the acknowledge, the host clocks out the 16-bit word one strobe at a time. The word is always a full aligned word. For a byte read, the host chooses the upper or lower half from the parity of the address it sent.

Top module: `dbgpin_read_ctrl`

## Requirements
- R1: While `rst_ni` is low, `drive_low_o`, `drive_high_o` and `bus_req_o` are all 0.
- R2: A 24-bit command arrives most significant bit first on ticks that carry `bit_stb_i`. Bits 23..16 are the opcode and bits 15..0 are the address. If the opcode equals `RD_OP` (default 8'hE4), `bus_req_o` rises after the last command bit. While the request is pending, `bus_addr_o` is the address with bit 0 forced to 0. `bus_req_o` falls in the cycle after `bus_gnt_i` is sampled high.
- R3: A command whose opcode differs from `RD_OP` produces no bus request and no pin drive, and the next command is received normally.
- R4: Let k be the tick that carries the last command bit. The acknowledge starts (`drive_low_o` rises) at the first tick, counted after k, that is at least the 16th such tick (`DLY`) and at which the read data has been captured. Data that arrives with `bus_rvalid_i` in that same tick counts as captured.
- R5: The acknowledge holds `drive_low_o` high for exactly 16 ticks (`ACK_LEN`).
- R6: `drive_high_o` is high for exactly one tick, directly after the acknowledge low time. It is never high at any other time, and never at the same time as `drive_low_o`.
- R7: The word returned on the bus is sent most significant bit first, one bit for each host strobe. A 0 bit drives `drive_low_o` high for the one tick after its strobe. A 1 bit leaves the pin released. The full word is returned for both even and odd addresses.
- R8: While a command is being received, and while the block waits for data, the pin is never driven. Strobes that arrive during the wait or during the acknowledge are ignored.
- R9: One tick after the 16th data bit, the block returns to command reception with the pin released.
- R10: Nothing on the pin changes in a cycle without `dbg_tick_i`, so every duration above is measured in ticks, whatever the tick rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dbg_tick_i | input | 1 | Debug clock enable, one core cycle per debug tick |
| bit_stb_i | input | 1 | Host bit strobe, taken only on a tick |
| pin_i | input | 1 | Sampled pin level for the strobed host bit |
| drive_low_o | output | 1 | Pull the pin low |
| drive_high_o | output | 1 | Actively drive the pin high (speedup) |
| bus_req_o | output | 1 | Memory bus cycle request |
| bus_addr_o | output | 16 | Word-aligned read address |
| bus_gnt_i | input | 1 | Bus cycle granted |
| bus_rvalid_i | input | 1 | Read data valid |
| bus_rdata_i | input | 16 | Read data word |

## Verification
Two events can land in the same cycle: the arrival of read data and the tick that ends the minimum decode delay. In that case the block has to capture the word and open the acknowledge on one edge. The bench provokes this by running the tick on every cycle and setting the bus latency so that `bus_rvalid_i` arrives exactly on the 16th tick after the last command bit. It then counts the released ticks before the acknowledge and expects exactly 16. With one cycle more latency it expects 17, and it checks that the word shifted out afterwards matches the one delivered in that shared cycle.

// File: rtl/dbgpin_pkg.sv
package dbgpin_pkg;
  typedef enum logic [2:0] {
    ST_CMD,
    ST_WAIT,
    ST_ACK_LO,
    ST_ACK_HI,
    ST_SEND
  } st_e;
endpackage

// File: rtl/dbgpin_cmd_rx.sv
module dbgpin_cmd_rx #(
  parameter int OP_W = 8,
  parameter int AW   = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            shift_i,
  input  logic            bit_i,
  output logic            last_o,
  output logic [OP_W-1:0] op_o,
  output logic [AW-1:0]   addr_o
);
  localparam int TOT = OP_W + AW;
  localparam int CW  = $clog2(TOT + 1);

  logic [TOT-2:0] sr_q;
  logic [CW-1:0]  cnt_q;
  logic [TOT-1:0] nxt;

  assign nxt    = {sr_q, bit_i};
  assign last_o = shift_i && (cnt_q == CW'(TOT - 1));
  assign op_o   = nxt[TOT-1 -: OP_W];
  assign addr_o = nxt[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (shift_i) begin
      sr_q  <= nxt[TOT-2:0];
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(TOT));
endmodule

// File: rtl/dbgpin_bus_port.sv
module dbgpin_bus_port #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic          gnt_i,
  input  logic          rvalid_i,
  input  logic [DW-1:0] rdata_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic          hit_o,
  output logic          have_o,
  output logic [DW-1:0] data_o
);
  logic          req_q, pend_q, have_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  // data may be accepted together with the grant
  assign hit_o  = rvalid_i && (pend_q || (req_q && gnt_i));
  assign data_o = hit_o ? rdata_i : data_q;
  assign req_o  = req_q;
  assign addr_o = addr_q;
  assign have_o = have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
      have_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (start_i) begin
      req_q  <= 1'b1;
      pend_q <= 1'b0;
      have_q <= 1'b0;
      addr_q <= addr_i & ~AW'(1);
    end else begin
      if (req_q && gnt_i) begin
        req_q  <= 1'b0;
        pend_q <= !rvalid_i;
      end else if (pend_q && rvalid_i) begin
        pend_q <= 1'b0;
      end
      if (hit_o) begin
        data_q <= rdata_i;
        have_q <= 1'b1;
      end
    end
  end

  p_req_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && gnt_i |=> !req_o);
  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !gnt_i |=> $stable(addr_o));
  p_addr_even_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> !addr_o[0]);
endmodule

// File: rtl/dbgpin_tx.sv
module dbgpin_tx #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          shift_i,
  output logic          low_o,
  output logic          done_o
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] sr_q;
  logic [CW-1:0] cnt_q;
  logic          low_q;

  assign low_o  = low_q;
  assign done_o = (cnt_q == CW'(DW));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
      low_q <= 1'b0;
    end else if (load_i) begin
      sr_q  <= data_i;
      cnt_q <= '0;
      low_q <= 1'b0;
    end else if (tick_i) begin
      if (shift_i) begin
        low_q <= ~sr_q[DW-1];
        sr_q  <= {sr_q[DW-2:0], 1'b0};
        cnt_q <= cnt_q + 1'b1;
      end else begin
        low_q <= 1'b0;
      end
    end
  end

  p_bits_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DW));
endmodule

// File: rtl/dbgpin_read_ctrl.sv
module dbgpin_read_ctrl
  import dbgpin_pkg::*;
#(
  parameter int              OP_W    = 8,
  parameter int              AW      = 16,
  parameter int              DW      = 16,
  parameter int              DLY     = 16,
  parameter int              ACK_LEN = 16,
  parameter logic [OP_W-1:0] RD_OP   = 8'hE4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dbg_tick_i,
  input  logic          bit_stb_i,
  input  logic          pin_i,
  output logic          drive_low_o,
  output logic          drive_high_o,
  output logic          bus_req_o,
  output logic [AW-1:0] bus_addr_o,
  input  logic          bus_gnt_i,
  input  logic          bus_rvalid_i,
  input  logic [DW-1:0] bus_rdata_i
);
  localparam int DCW = $clog2(DLY + 1);
  localparam int AKW = (ACK_LEN > 1) ? $clog2(ACK_LEN) : 1;

  st_e st_q, st_d;
  logic [DCW-1:0] dly_q;
  logic [AKW-1:0] ack_q;

  logic            rx_shift, rx_last;
  logic [OP_W-1:0] rx_op;
  logic [AW-1:0]   rx_addr;
  logic            start, dly_ok, ack_go;
  logic            bus_hit, bus_have;
  logic [DW-1:0]   bus_data;
  logic            tx_shift, tx_low, tx_done;

  assign rx_shift = dbg_tick_i && bit_stb_i && (st_q == ST_CMD);
  assign start    = rx_last && (rx_op == RD_OP);
  assign dly_ok   = dly_q >= DCW'(DLY - 1);
  assign ack_go   = dbg_tick_i && (st_q == ST_WAIT) && dly_ok && (bus_have || bus_hit);
  assign tx_shift = dbg_tick_i && bit_stb_i && (st_q == ST_SEND) && !tx_done;

  dbgpin_cmd_rx #(.OP_W(OP_W), .AW(AW)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(rx_shift),
    .bit_i  (pin_i),
    .last_o (rx_last),
    .op_o   (rx_op),
    .addr_o (rx_addr)
  );

  dbgpin_bus_port #(.AW(AW), .DW(DW)) u_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .addr_i  (rx_addr),
    .gnt_i   (bus_gnt_i),
    .rvalid_i(bus_rvalid_i),
    .rdata_i (bus_rdata_i),
    .req_o   (bus_req_o),
    .addr_o  (bus_addr_o),
    .hit_o   (bus_hit),
    .have_o  (bus_have),
    .data_o  (bus_data)
  );

  dbgpin_tx #(.DW(DW)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (dbg_tick_i),
    .load_i (ack_go),
    .data_i (bus_data),
    .shift_i(tx_shift),
    .low_o  (tx_low),
    .done_o (tx_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_CMD:    if (start) st_d = ST_WAIT;
      ST_WAIT:   if (ack_go) st_d = ST_ACK_LO;
      ST_ACK_LO: if (dbg_tick_i && ack_q == AKW'(ACK_LEN - 1)) st_d = ST_ACK_HI;
      ST_ACK_HI: if (dbg_tick_i) st_d = ST_SEND;
      ST_SEND:   if (dbg_tick_i && tx_done) st_d = ST_CMD;
      default:   st_d = ST_CMD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_CMD;
      dly_q <= '0;
      ack_q <= '0;
    end else begin
      st_q <= st_d;
      if (start) dly_q <= '0;
      else if (st_q == ST_WAIT && dbg_tick_i && dly_q != DCW'(DLY)) dly_q <= dly_q + 1'b1;
      if (ack_go) ack_q <= '0;
      else if (st_q == ST_ACK_LO && dbg_tick_i) ack_q <= ack_q + 1'b1;
    end
  end

  assign drive_low_o  = (st_q == ST_ACK_LO) || tx_low;
  assign drive_high_o = (st_q == ST_ACK_HI);

  p_no_dual_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drive_low_o && drive_high_o));
  p_spd_after_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_high_o) |-> $past(drive_low_o));
  p_spd_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_high_o && dbg_tick_i |=> !drive_high_o);
  p_hold_no_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbg_tick_i |=> $stable(drive_low_o) && $stable(drive_high_o));
  p_quiet_rx_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CMD || st_q == ST_WAIT) |-> !drive_low_o && !drive_high_o);
  p_ack_has_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACK_LO) |-> bus_have);
endmodule

// File: tb/tb_dbgpin_read_ctrl.sv
module tb_dbgpin_read_ctrl;
  localparam logic [7:0] RD_OP = 8'hE4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick;
  logic        stb = 1'b0;
  logic        pin = 1'b0;
  logic        gnt = 1'b0;
  logic        rvalid = 1'b0;
  logic [15:0] rdata = '0;
  logic        drive_low_o, drive_high_o, bus_req_o;
  logic [15:0] bus_addr_o;

  int tdiv = 1;
  int tcnt = 0;
  int gl = 0;
  int rl = 0;
  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];

  always #5 clk = ~clk;

  always @(posedge clk) tcnt <= (tcnt + 1 >= tdiv) ? 0 : tcnt + 1;
  assign tick = (tcnt == 0);

  dbgpin_read_ctrl dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .dbg_tick_i  (tick),
    .bit_stb_i   (stb),
    .pin_i       (pin),
    .drive_low_o (drive_low_o),
    .drive_high_o(drive_high_o),
    .bus_req_o   (bus_req_o),
    .bus_addr_o  (bus_addr_o),
    .bus_gnt_i   (gnt),
    .bus_rvalid_i(rvalid),
    .bus_rdata_i (rdata)
  );

  function automatic logic [15:0] mk(logic [15:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] ^ 8'hC3};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus model: scoreboard pop and compare of the requested address
  initial begin
    logic [15:0] e;
    forever begin
      @(negedge clk);
      if (rst_ni && bus_req_o) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected bus request", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk(bus_addr_o == e, "R2 aligned bus address", bus_addr_o, e);
        end
        repeat (gl) @(negedge clk);
        gnt = 1'b1;
        if (rl == 0) begin
          rvalid = 1'b1;
          rdata  = mk(bus_addr_o);
        end
        @(negedge clk);
        gnt = 1'b0;
        rvalid = 1'b0;
        chk(!bus_req_o, "R2 request drops after grant", bus_req_o, 0);
        if (rl > 0) begin
          repeat (rl - 1) @(negedge clk);
          rvalid = 1'b1;
          rdata  = mk(bus_addr_o);
          @(negedge clk);
          rvalid = 1'b0;
        end
      end
    end
  end

  task automatic send_bit(logic b);
    @(negedge clk);
    while (!tick) @(negedge clk);
    pin = b;
    stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    pin = 1'b0;
  endtask

  task automatic rd(logic [7:0] op, logic [15:0] addr, int g, int r, bit stray, int exp_wait);
    logic [23:0] w;
    logic [15:0] got;
    int wslots, lslots, hslots, guard;
    bit bad;
    w = {op, addr};
    gl = g;
    rl = r;
    if (op == RD_OP) exp_q.push_back({addr[15:1], 1'b0});
    bad = 1'b0;
    for (int i = 23; i >= 0; i--) begin
      send_bit(w[i]);
      if (drive_low_o || drive_high_o) bad = 1'b1;
    end
    chk(!bad, "R8 pin quiet during command", bad, 0);
    if (op != RD_OP) begin
      bad = 1'b0;
      repeat (60) begin
        @(negedge clk);
        if (bus_req_o || drive_low_o || drive_high_o) bad = 1'b1;
      end
      chk(!bad, "R3 foreign opcode ignored", bad, 0);
      return;
    end
    wslots = 0;
    guard = 0;
    stb = stray;
    pin = 1'b0;
    while (guard < 4000) begin
      if (tick) begin
        if (drive_low_o || drive_high_o) break;
        wslots++;
      end
      @(negedge clk);
      guard++;
    end
    stb = 1'b0;
    chk(wslots == exp_wait, stray ? "R8 R4 ack timing with stray strobes" : "R4 ack start tick",
        wslots, exp_wait);
    lslots = 0;
    bad = 1'b0;
    while (guard < 4000) begin
      if (tick) begin
        if (drive_high_o) break;
        if (!drive_low_o) bad = 1'b1;
        lslots++;
      end
      @(negedge clk);
      guard++;
    end
    chk(lslots == 16 && !bad, "R5 ack low length", lslots, 16);
    hslots = 0;
    while (guard < 4000) begin
      if (tick) begin
        if (!drive_high_o) break;
        hslots++;
      end
      @(negedge clk);
      guard++;
    end
    chk(hslots == 1, "R6 speedup one tick", hslots, 1);
    chk(!drive_low_o && !drive_high_o, "R6 released after speedup",
        {drive_low_o, drive_high_o}, 0);
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      while (!tick) @(negedge clk);
      stb = 1'b1;
      @(negedge clk);
      stb = 1'b0;
      got[i] = !drive_low_o;
    end
    chk(got == mk({addr[15:1], 1'b0}), "R7 returned word", got, mk({addr[15:1], 1'b0}));
    repeat (2 * tdiv + 2) @(negedge clk);
    chk(!drive_low_o && !drive_high_o, "R9 released after last bit",
        {drive_low_o, drive_high_o}, 0);
  endtask

  function automatic int ew(int g, int r);
    return (1 + g + r > 16) ? 1 + g + r : 16;
  endfunction

  initial begin
    repeat (4) begin
      @(negedge clk);
      chk(!drive_low_o && !drive_high_o && !bus_req_o, "R1 reset outputs idle",
          {drive_low_o, drive_high_o, bus_req_o}, 0);
    end
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    rd(RD_OP, 16'h1234, 0, 15, 1'b0, ew(0, 15));  // R4 data on the 16th tick
    rd(RD_OP, 16'h1235, 0, 16, 1'b0, ew(0, 16));  // R4 one tick late, odd address R7
    rd(RD_OP, 16'hFFFF, 3, 30, 1'b0, ew(3, 30));  // R4 long latency
    rd(RD_OP, 16'h0000, 0, 0, 1'b0, ew(0, 0));    // R4 early data, grant and data together
    rd(8'h00, 16'h4321, 0, 0, 1'b0, 16);          // R3
    rd(RD_OP, 16'hBEEF, 1, 4, 1'b1, ew(1, 4));    // R8 stray strobes, R3 recovery
    tdiv = 3;                                      // R10 slower tick
    repeat (4) @(negedge clk);
    rd(RD_OP, 16'h8001, 1, 2, 1'b0, 16);
    rd(RD_OP, 16'h5AA4, 0, 3, 1'b1, 16);

    chk(exp_q.size() == 0, "R2 every read requested the bus", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1..R10 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule